// File: doc/BRIEF.md
# Translated DMA Channel

A single bus-master DMA channel that moves a block of bytes between a byte stream on the device side and physical memory. Software programs a logical start address, a byte count, a run bit and a direction bit. A requester on the device side then starts a transfer and says which way the data flows and how many bytes it can take. Every logical 4 KB page is mapped through a 32-bit entry that the engine reads from an in-memory page table. The table entry for a page is read again each time the logical address enters a new page.

Within a page, data moves in chunks. The size of each chunk is 256, 16 or 1 byte, chosen from the alignment of the physical address and from the bytes still to move. The memory port is byte-wide and uses a request/grant handshake. Each beat carries the length of the burst it belongs to. The transfer stops as soon as either the programmed window or the requested length is used up. When it stops, the count register is cleared and a one-cycle done pulse is raised.

Top module: `tdma_top`

## Requirements
- R1: Registers, addressed by byte offset on `reg_addr_i`, all reset to 0 and are read/write:
  - mode at 0x00.
  - enable at 0x08. Bit 0 is run. Bit 1 set means memory-to-device; bit 1 clear means device-to-memory.
  - count at 0x10.
  - logical start at 0x18.
  - table base at 0x20.
  - table limit at 0x28.
  - Offset 0x30 is an invalidate slot: a write there changes nothing and the slot reads 0.
  - Any other offset reads 0.
- R2: A start pulse is refused if run is clear or if `xfer_to_dev_i` differs from enable bit 1. A refused start gives a one-cycle `refused_o` in the next cycle, makes no memory access and leaves count unchanged.
- R3: Before the first data beat in each logical page, the engine makes four byte reads with `mem_len_o`=4. They are at table base + (logical address >> 12) * 8 + 0..3, in that order.
- R4: With `big_endian_i`=1, the first fetched byte is the most significant byte of the entry. With `big_endian_i`=0, it is the least significant.
- R5: The physical address is the entry with its low 12 bits cleared, plus the low 12 bits of the logical address.
- R6: The bytes remaining are the smaller of the requested length left and (start + count − current logical address). A chunk is chosen as follows:
  - 256 bytes if the physical address is 256-aligned and at least 256 bytes remain.
  - Otherwise 16 bytes if the physical address is 16-aligned and at least 16 bytes remain.
  - Otherwise 1 byte.
  - Every beat of the chunk shows the chunk size on `mem_len_o`.
- R7: A new table read follows each crossing of a 4 KB logical boundary, and no chunk spans two pages.
- R8: When the bytes remaining reach 0, `done_o` pulses for one cycle, `busy_o` falls in the next cycle and count reads 0. If a transfer starts with nothing remaining, it finishes without any memory access.
- R9: In memory-to-device mode, each byte read from memory appears on `dev_data_o` with `dev_valid_o` one cycle after its beat. In device-to-memory mode, `mem_wdata_o` carries `dev_data_i` and `dev_ack_o` marks each byte taken.
- R10: Writes to the channel registers (mode, enable, count, start) are ignored while `busy_o` is high.
- R11: A beat completes on a rising edge where `mem_req_o` and `mem_gnt_i` are both high. While the grant is low, the request, address and direction hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Byte order used to assemble table entries |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| xfer_start_i | input | 1 | Start pulse from the device-side requester |
| xfer_to_dev_i | input | 1 | Requested direction: 1 means memory to device |
| xfer_len_i | input | 16 | Bytes the requester can take or give |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| refused_o | output | 1 | One-cycle pulse when a start is refused |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write to memory |
| mem_addr_o | output | 32 | Physical byte address of the beat |
| mem_len_o | output | 9 | Length of the burst this beat belongs to |
| mem_wdata_o | output | 8 | Write data |
| mem_gnt_i | input | 1 | Beat accepted |
| mem_rdata_i | input | 8 | Read data, valid with the grant |
| dev_data_o | output | 8 | Byte to the device |
| dev_valid_o | output | 1 | `dev_data_o` is valid |
| dev_data_i | input | 8 | Byte from the device |
| dev_ack_o | output | 1 | `dev_data_i` taken this cycle |

## Verification
A wrong page index, a stale table entry or a dropped page-crossing flag shows at the memory port on the very next granted beat, as an address the scoreboard does not expect. A wrong chunk choice shows at the same point, as a `mem_len_o` value the scoreboard does not expect. A wrong byte order in the entry assembly shows as a wrong physical page on the first data beat after each table read. Counting errors in the remaining-bytes logic show as extra or missing beats, as a done pulse that comes early or late, or as a count register that does not read 0 afterwards. A missed or misplaced byte on the device stream is caught one cycle after the read beat that should have produced it.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam logic [5:0] OFS_MODE  = 6'h00;
  localparam logic [5:0] OFS_ENA   = 6'h08;
  localparam logic [5:0] OFS_CNT   = 6'h10;
  localparam logic [5:0] OFS_START = 6'h18;
  localparam logic [5:0] OFS_TBASE = 6'h20;
  localparam logic [5:0] OFS_TLIM  = 6'h28;
  localparam logic [5:0] OFS_INVAL = 6'h30;

  localparam int unsigned ENA_RUN   = 0;
  localparam int unsigned ENA_TODEV = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_FETCH,
    ST_XFER,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/tdma_regfile.sv
module tdma_regfile import tdma_pkg::*; #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [5:0]    addr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          clr_cnt_i,
  output logic [AW-1:0] rdata_o,
  output logic          run_o,
  output logic          to_dev_o,
  output logic [AW-1:0] cnt_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] tbase_o
);
  logic [AW-1:0] mode_q, ena_q, cnt_q, start_q, tbase_q, tlim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ena_q   <= '0;
      cnt_q   <= '0;
      start_q <= '0;
      tbase_q <= '0;
      tlim_q  <= '0;
    end else begin
      if (clr_cnt_i) cnt_q <= '0;
      if (we_i) begin
        case (addr_i)
          OFS_MODE:  if (!busy_i) mode_q  <= wdata_i;
          OFS_ENA:   if (!busy_i) ena_q   <= wdata_i;
          OFS_CNT:   if (!busy_i) cnt_q   <= wdata_i;
          OFS_START: if (!busy_i) start_q <= wdata_i;
          OFS_TBASE: tbase_q <= wdata_i;
          OFS_TLIM:  tlim_q  <= wdata_i;
          default: ;  // invalidate slot and holes: no effect
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      OFS_MODE:  rdata_o = mode_q;
      OFS_ENA:   rdata_o = ena_q;
      OFS_CNT:   rdata_o = cnt_q;
      OFS_START: rdata_o = start_q;
      OFS_TBASE: rdata_o = tbase_q;
      OFS_TLIM:  rdata_o = tlim_q;
      default:   rdata_o = '0;
    endcase
  end

  assign run_o    = ena_q[ENA_RUN];
  assign to_dev_o = ena_q[ENA_TODEV];
  assign cnt_o    = cnt_q;
  assign start_o  = start_q;
  assign tbase_o  = tbase_q;
endmodule

// File: rtl/tdma_chunk_sel.sv
module tdma_chunk_sel #(
  parameter int unsigned REM_W   = 33,
  parameter int unsigned MAX_LOG = 8,
  parameter int unsigned MID_LOG = 4,
  parameter int unsigned CW      = MAX_LOG + 1
) (
  input  logic [MAX_LOG-1:0] phys_lo_i,
  input  logic [REM_W-1:0]   rem_i,
  output logic [CW-1:0]      len_o
);
  localparam int unsigned BIG = 1 << MAX_LOG;
  localparam int unsigned MID = 1 << MID_LOG;

  always_comb begin
    if (phys_lo_i == '0 && rem_i >= REM_W'(BIG))
      len_o = CW'(BIG);
    else if (phys_lo_i[MID_LOG-1:0] == '0 && rem_i >= REM_W'(MID))
      len_o = CW'(MID);
    else
      len_o = CW'(1);
  end
endmodule

// File: rtl/tdma_walker.sv
module tdma_walker import tdma_pkg::*; #(
  parameter int unsigned AW          = 32,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned ENTRY_SHIFT = 3,
  parameter int unsigned MAX_LOG     = 8,
  parameter int unsigned CW          = MAX_LOG + 1,
  parameter int unsigned REM_W       = AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               big_endian_i,
  input  logic               start_i,
  input  logic               to_dev_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               run_i,
  input  logic               ena_to_dev_i,
  input  logic [AW-1:0]      cnt_i,
  input  logic [AW-1:0]      start_addr_i,
  input  logic [AW-1:0]      tbase_i,
  input  logic [CW-1:0]      chunk_len_i,
  output logic [REM_W-1:0]   rem_o,
  output logic [MAX_LOG-1:0] phys_lo_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               refused_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [CW-1:0]      mem_len_o,
  output logic [7:0]         mem_wdata_o,
  input  logic               mem_gnt_i,
  input  logic [7:0]         mem_rdata_i,
  output logic [7:0]         dev_data_o,
  output logic               dev_valid_o,
  input  logic [7:0]         dev_data_i,
  output logic               dev_ack_o
);
  localparam int unsigned ENTRY_BYTES = AW / 8;
  localparam int unsigned FC_W = $clog2(ENTRY_BYTES);
  localparam logic [AW-1:0] PG_MASK = {{(AW-PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  walk_st_e st_q;
  logic [REM_W-1:0] cur_q, end_q, span, left_ext;
  logic [LEN_W-1:0] left_q;
  logic [AW-1:0]    entry_q, phys, ent_addr;
  logic [FC_W-1:0]  fcnt_q;
  logic [CW-1:0]    beats_q, blen_q;
  logic need_lk_q, to_dev_q, refused_q, dev_valid_q;
  logic [7:0] dev_data_q;
  logic beat, go;

  always_comb begin
    span     = end_q - cur_q;
    left_ext = REM_W'(left_q);
    rem_o    = (left_ext < span) ? left_ext : span;
  end

  assign phys      = (entry_q & ~PG_MASK) | (cur_q[AW-1:0] & PG_MASK);
  assign phys_lo_o = phys[MAX_LOG-1:0];
  assign ent_addr  = tbase_i
                   + ({{PAGE_BITS{1'b0}}, cur_q[AW-1:PAGE_BITS]} << ENTRY_SHIFT)
                   + AW'(fcnt_q);

  assign go   = run_i && (to_dev_i == ena_to_dev_i);
  assign beat = mem_req_o && mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      end_q       <= '0;
      left_q      <= '0;
      entry_q     <= '0;
      fcnt_q      <= '0;
      beats_q     <= '0;
      blen_q      <= '0;
      need_lk_q   <= 1'b0;
      to_dev_q    <= 1'b0;
      refused_q   <= 1'b0;
      dev_valid_q <= 1'b0;
      dev_data_q  <= '0;
    end else begin
      refused_q   <= 1'b0;
      dev_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (go) begin
              cur_q     <= REM_W'(start_addr_i);
              end_q     <= REM_W'(start_addr_i) + REM_W'(cnt_i);
              left_q    <= len_i;
              to_dev_q  <= to_dev_i;
              need_lk_q <= 1'b1;
              st_q      <= ST_CHK;
            end else begin
              refused_q <= 1'b1;
            end
          end
        end
        ST_CHK: begin
          if (rem_o == '0) begin
            st_q <= ST_DONE;
          end else if (need_lk_q) begin
            fcnt_q <= '0;
            st_q   <= ST_FETCH;
          end else begin
            beats_q <= chunk_len_i;
            blen_q  <= chunk_len_i;
            st_q    <= ST_XFER;
          end
        end
        ST_FETCH: begin
          if (beat) begin
            entry_q <= big_endian_i ? {entry_q[AW-9:0], mem_rdata_i}
                                    : {mem_rdata_i, entry_q[AW-1:8]};
            fcnt_q  <= fcnt_q + FC_W'(1);
            if (fcnt_q == FC_W'(ENTRY_BYTES - 1)) begin
              need_lk_q <= 1'b0;
              st_q      <= ST_CHK;
            end
          end
        end
        ST_XFER: begin
          if (beat) begin
            cur_q   <= cur_q + REM_W'(1);
            left_q  <= left_q - LEN_W'(1);
            beats_q <= beats_q - CW'(1);
            if (to_dev_q) begin
              dev_valid_q <= 1'b1;
              dev_data_q  <= mem_rdata_i;
            end
            if (&cur_q[PAGE_BITS-1:0]) need_lk_q <= 1'b1;
            if (beats_q == CW'(1)) st_q <= ST_CHK;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == ST_FETCH) || (st_q == ST_XFER);
  assign mem_we_o    = (st_q == ST_XFER) && !to_dev_q;
  assign mem_addr_o  = (st_q == ST_FETCH) ? ent_addr : phys;
  assign mem_len_o   = (st_q == ST_FETCH) ? CW'(ENTRY_BYTES) : blen_q;
  assign mem_wdata_o = dev_data_i;
  assign dev_ack_o   = beat && mem_we_o;
  assign dev_data_o  = dev_data_q;
  assign dev_valid_o = dev_valid_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign refused_o   = refused_q;
endmodule

// File: rtl/tdma_top.sv
module tdma_top #(
  parameter int unsigned AW          = 32,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned ENTRY_SHIFT = 3,
  parameter int unsigned MAX_LOG     = 8,
  parameter int unsigned MID_LOG     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             big_endian_i,
  input  logic             reg_we_i,
  input  logic [5:0]       reg_addr_i,
  input  logic [AW-1:0]    reg_wdata_i,
  output logic [AW-1:0]    reg_rdata_o,
  input  logic             xfer_start_i,
  input  logic             xfer_to_dev_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             refused_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [MAX_LOG:0] mem_len_o,
  output logic [7:0]       mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic [7:0]       mem_rdata_i,
  output logic [7:0]       dev_data_o,
  output logic             dev_valid_o,
  input  logic [7:0]       dev_data_i,
  output logic             dev_ack_o
);
  localparam int unsigned CW    = MAX_LOG + 1;
  localparam int unsigned REM_W = AW + 1;

  logic run, ena_to_dev, clr_cnt;
  logic [AW-1:0] cnt, start_addr, tbase;
  logic [REM_W-1:0] rem;
  logic [MAX_LOG-1:0] phys_lo;
  logic [CW-1:0] chunk_len;

  tdma_regfile #(.AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy_o),
    .clr_cnt_i (clr_cnt),
    .rdata_o   (reg_rdata_o),
    .run_o     (run),
    .to_dev_o  (ena_to_dev),
    .cnt_o     (cnt),
    .start_o   (start_addr),
    .tbase_o   (tbase)
  );

  tdma_chunk_sel #(
    .REM_W(REM_W), .MAX_LOG(MAX_LOG), .MID_LOG(MID_LOG), .CW(CW)
  ) u_chunk (
    .phys_lo_i (phys_lo),
    .rem_i     (rem),
    .len_o     (chunk_len)
  );

  tdma_walker #(
    .AW(AW), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS), .ENTRY_SHIFT(ENTRY_SHIFT),
    .MAX_LOG(MAX_LOG), .CW(CW), .REM_W(REM_W)
  ) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .big_endian_i (big_endian_i),
    .start_i      (xfer_start_i),
    .to_dev_i     (xfer_to_dev_i),
    .len_i        (xfer_len_i),
    .run_i        (run),
    .ena_to_dev_i (ena_to_dev),
    .cnt_i        (cnt),
    .start_addr_i (start_addr),
    .tbase_i      (tbase),
    .chunk_len_i  (chunk_len),
    .rem_o        (rem),
    .phys_lo_o    (phys_lo),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .refused_o    (refused_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_len_o    (mem_len_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rdata_i  (mem_rdata_i),
    .dev_data_o   (dev_data_o),
    .dev_valid_o  (dev_valid_o),
    .dev_data_i   (dev_data_i),
    .dev_ack_o    (dev_ack_o)
  );

  assign clr_cnt = done_o;
endmodule

// File: rtl/tdma_checker.sv
module tdma_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          refused_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_gnt_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [CW-1:0] mem_len_o,
  input logic          dev_valid_o
);
  // R8: no memory traffic while idle
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  // R8: done is a single pulse and ends the busy phase
  a_r8_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));

  // R2: a refusal never starts traffic
  a_r2_refuse_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refused_o |-> (!busy_o && !mem_req_o));

  // R11: stalled beat holds request, address and direction
  a_r11_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R6: burst length is always a single power of two
  a_r6_len_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_len_o) == 1));

  // R9: device byte only follows a granted memory read
  a_r9_dev_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o |-> $past(mem_req_o && mem_gnt_i && !mem_we_o));
endmodule

bind tdma_top tdma_checker #(.AW(AW), .CW(MAX_LOG + 1)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .refused_o   (refused_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_o  (mem_addr_o),
  .mem_len_o   (mem_len_o),
  .dev_valid_o (dev_valid_o)
);

// File: tb/tdma_top_tb_top.sv
module tdma_top_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        big_endian;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        xfer_start, xfer_to_dev;
  logic [15:0] xfer_len;
  logic        busy, done, refused;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr;
  logic [8:0]  mem_len;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  dev_dout, dev_din;
  logic        dev_valid, dev_ack;

  tdma_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big_endian),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xfer_start_i(xfer_start), .xfer_to_dev_i(xfer_to_dev), .xfer_len_i(xfer_len),
    .busy_o(busy), .done_o(done), .refused_o(refused),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .dev_data_o(dev_dout), .dev_valid_o(dev_valid), .dev_data_i(dev_din), .dev_ack_o(dev_ack)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [8:0]  len;
    logic        we;
    logic [7:0]  wdata;
  } beat_t;

  beat_t      exp_beats[$];
  logic [7:0] exp_dev[$];
  logic [7:0] mem_m [int];
  int checks = 0, errors = 0, cyc = 0, dev_idx = 0, gnt_mode = 0;
  string beat_tag = "R3 R5 R6";
  localparam logic [31:0] TBASE = 32'h0000_8000;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5C;
  endfunction

  function automatic logic [7:0] rd_mem(input logic [31:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return pat(a);
  endfunction

  function automatic logic [7:0] dev_byte(input int i);
    return 8'hA0 ^ 8'(i * 3);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model, scoreboard monitor and watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n && dev_valid) begin
      if (exp_dev.size() == 0) chk(0, "R9", "unexpected device byte", {24'h0, dev_dout}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_dev.pop_front();
        chk(dev_dout == e, "R9", "device byte", {24'h0, dev_dout}, {24'h0, e});
      end
    end
    mem_gnt   = (gnt_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    mem_rdata = rd_mem(mem_addr);
    dev_din   = dev_byte(dev_idx);
    #1;
    if (rst_n && mem_req && mem_gnt) begin
      if (exp_beats.size() == 0) begin
        chk(0, beat_tag, "unexpected beat addr", mem_addr, 32'h0);
      end else begin
        beat_t b;
        b = exp_beats.pop_front();
        chk(mem_addr == b.addr && mem_len == b.len && mem_we == b.we,
            beat_tag, "beat addr/len/we", {mem_addr[21:0], mem_len, mem_we},
            {b.addr[21:0], b.len, b.we});
        if (b.we) begin
          chk(mem_wdata == b.wdata && dev_ack, "R9", "write byte/ack",
              {23'h0, dev_ack, mem_wdata}, {23'h0, 1'b1, b.wdata});
        end
      end
      if (mem_we) begin
        mem_m[int'(mem_addr)] = mem_wdata;
        dev_idx++;
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic put_entry(input int page, input logic [31:0] v, input bit be);
    for (int j = 0; j < 4; j++) begin
      logic [31:0] ea;
      ea = TBASE + page * 8 + j;
      mem_m[int'(ea)] = be ? v[31 - 8*j -: 8] : v[8*j +: 8];
    end
  endtask

  // reference walk built from the requirements
  task automatic model_xfer(input logic [31:0] st, input logic [31:0] cnt,
                            input int len, input bit to_dev, input bit be);
    longint cur, endv, rem;
    int left, wk;
    bit need;
    logic [31:0] ent, phys, ea;
    int n;
    cur = st; endv = longint'(st) + longint'(cnt); left = len; need = 1; ent = 0; wk = dev_idx;
    forever begin
      rem = (longint'(left) < endv - cur) ? longint'(left) : endv - cur;
      if (rem <= 0) break;
      if (need) begin
        ea = TBASE + 32'((cur >> 12) * 8);
        for (int j = 0; j < 4; j++) exp_beats.push_back('{ea + j, 9'd4, 1'b0, 8'h0});
        ent = be ? {rd_mem(ea), rd_mem(ea+1), rd_mem(ea+2), rd_mem(ea+3)}
                 : {rd_mem(ea+3), rd_mem(ea+2), rd_mem(ea+1), rd_mem(ea)};
        need = 0;
      end
      phys = (ent & ~32'hFFF) | (32'(cur) & 32'hFFF);
      if (phys[7:0] == 0 && rem >= 256) n = 256;
      else if (phys[3:0] == 0 && rem >= 16) n = 16;
      else n = 1;
      for (int j = 0; j < n; j++) begin
        exp_beats.push_back('{phys + j, 9'(n), !to_dev, dev_byte(wk)});
        if (to_dev) exp_dev.push_back(rd_mem(phys + j));
        else wk++;
      end
      cur += n; left -= n;
      if ((cur & 64'hFFF) == 0) need = 1;
    end
  endtask

  task automatic kick(input bit to_dev, input logic [15:0] len);
    @(negedge clk);
    xfer_start = 1'b1; xfer_to_dev = to_dev; xfer_len = len;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, req, "done pulse seen", 32'(seen), 32'h1);
  endtask

  initial begin
    logic [31:0] v;
    bit seen;
    rst_n = 1'b0; big_endian = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    xfer_start = 1'b0; xfer_to_dev = 1'b0; xfer_len = '0;
    mem_gnt = 1'b0; mem_rdata = '0; dev_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(6'h10, v); chk(v == 0, "R1", "count after reset", v, 0);
    rd(6'h08, v); chk(v == 0, "R1", "enable after reset", v, 0);
    chk(!busy && !done && !refused && !mem_req, "R8", "idle outputs after reset",
        {28'h0, busy, done, refused, mem_req}, 0);

    // R1 register access, invalidate slot and holes
    wr(6'h00, 32'h0000_5A5A);
    wr(6'h28, 32'h000F_FFF0);
    wr(6'h20, TBASE);
    wr(6'h30, 32'hFFFF_FFFF);
    rd(6'h00, v); chk(v == 32'h5A5A, "R1", "mode readback", v, 32'h5A5A);
    rd(6'h28, v); chk(v == 32'hF_FFF0, "R1", "limit readback", v, 32'hF_FFF0);
    rd(6'h20, v); chk(v == TBASE, "R1", "table base after invalidate", v, TBASE);
    rd(6'h30, v); chk(v == 0, "R1", "invalidate reads zero", v, 0);
    rd(6'h38, v); chk(v == 0, "R1", "hole reads zero", v, 0);

    // memory to device, big-endian entries, page crossing, stalled grants
    put_entry(1, 32'h0000_6FFF, 1'b1);
    put_entry(2, 32'h1234_4123, 1'b1);
    wr(6'h08, 32'h3);
    wr(6'h10, 32'h130);
    wr(6'h18, 32'h1FF0);
    gnt_mode = 1; beat_tag = "R3 R4 R5 R6 R7 R11";
    model_xfer(32'h1FF0, 32'h130, 16'h200, 1'b1, 1'b1);
    kick(1'b1, 16'h200);
    chk(busy, "R8", "busy after start", 32'(busy), 1);
    wr(6'h18, 32'hDEAD_0000);  // R10: ignored while busy
    wr(6'h08, 32'h0);
    wait_done("R8", seen);
    @(negedge clk);
    chk(!busy, "R8", "busy falls after done", 32'(busy), 0);
    chk(exp_beats.size() == 0, "R7", "all beats seen", exp_beats.size(), 0);
    chk(exp_dev.size() == 0, "R9", "all device bytes seen", exp_dev.size(), 0);
    rd(6'h10, v); chk(v == 0, "R8", "count cleared", v, 0);
    rd(6'h18, v); chk(v == 32'h1FF0, "R10", "start kept while busy", v, 32'h1FF0);
    rd(6'h08, v); chk(v == 32'h3, "R10", "enable kept while busy", v, 32'h3);

    // device to memory, little-endian entry, limited by requested length
    big_endian = 1'b0; gnt_mode = 0; beat_tag = "R4 R5 R6";
    put_entry(0, 32'h0000_3ABC, 1'b0);
    wr(6'h08, 32'h1);
    wr(6'h10, 32'h100);
    wr(6'h18, 32'h0003);
    model_xfer(32'h0003, 32'h100, 16'h25, 1'b0, 1'b0);
    kick(1'b0, 16'h25);
    wait_done("R6", seen);
    @(negedge clk);
    chk(exp_beats.size() == 0, "R6", "write beats complete", exp_beats.size(), 0);
    v = {24'h0, rd_mem(32'h3020)};
    chk(v[7:0] == dev_byte(29), "R9", "byte landed in memory", v, {24'h0, dev_byte(29)});

    // R2: direction mismatch
    beat_tag = "R2";
    wr(6'h08, 32'h3);
    wr(6'h10, 32'h40);
    kick(1'b0, 16'h10);
    chk(refused && !busy, "R2", "refused on direction mismatch", {30'h0, refused, busy}, 32'h2);
    repeat (4) @(negedge clk);
    rd(6'h10, v); chk(v == 32'h40, "R2", "count untouched by refusal", v, 32'h40);

    // R2: run bit clear
    wr(6'h08, 32'h2);
    kick(1'b1, 16'h10);
    chk(refused && !busy, "R2", "refused with run clear", {30'h0, refused, busy}, 32'h2);
    repeat (4) @(negedge clk);

    // R8: nothing remaining
    beat_tag = "R8";
    wr(6'h08, 32'h1);
    wr(6'h10, 32'h0);
    kick(1'b0, 16'h20);
    wait_done("R8", seen);
    @(negedge clk);
    chk(!busy && exp_beats.size() == 0, "R8", "empty transfer no traffic", 32'(busy), 0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule